// File: doc/BRIEF.md
# Idle-Mode Wakeup Request Generator

This block raises a wakeup request to the power and clock manager while a processor subsystem sits in its low-power idle state. The request is formed from level-sensitive interrupt lines, DMA event lines and a non-maskable interrupt. Each interrupt line and each DMA line has its own wake-enable bit. The non-maskable interrupt has no enable bit. All sources are further gated by a two-bit idle-mode field and by the subsystem's idle indication. The whole path from the source pins to `wake_req` is combinational, so it works while the clock is stopped.

The DMA line that caused a wakeup may drop again before the DMA engine is taken out of idle. For that case, a clocked status section keeps a sticky raw bit for every DMA line that was seen high while enabled for wake. It also provides a per-line interrupt enable, with separate set and clear registers. The AND of raw status and enable is readable as the masked status, and the OR of the masked bits drives `wake_irq`. Software reads the masked status to find out which channel needs a manual trigger.

Registers are reached through a plain single-cycle port. A write takes effect at the rising clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no back-pressure: every access is accepted in the cycle it is presented. The port uses word addresses:

| Address | Register |
| --- | --- |
| 0 | configuration, mode field at bits [3:2] |
| 1 / 2 | interrupt wake-enable, lines 31:0 / 63:32 |
| 3 / 4 | DMA wake-enable, lines 31:0 / 63:32 |
| 5 / 6 | raw status, write 1 to clear |
| 7 / 8 | masked status, read only |
| 9 / 10 | enable set |
| 11 / 12 | enable clear |

Any other address reads 0.

Top module: `idle_wake_gen`

## Requirements
- R1: `wake_req` can be high only while configuration bits [3:2] hold 2'b11. Any other mode value forces it low.
- R2: Interrupt line i contributes to `wake_req` only when bit i of the interrupt wake-enable is set. Lines 0–31 map to bits 31:0 at address 1, and lines 32–63 map to bits 31:0 at address 2.
- R3: DMA line i contributes to `wake_req` only when bit i of the DMA wake-enable is set (address 3 for lines 0–31, address 4 for lines 32–63). A DMA line that is not enabled sets no raw status bit.
- R4: `nmi_in` high drives `wake_req` high whenever the mode field is 2'b11 and `sys_idle` is high, whatever the enables hold.
- R5: `wake_req` is low while `sys_idle` is low.
- R6: `wake_req` is low whenever all enabled interrupt lines, all enabled DMA lines and `nmi_in` are low. It follows the sources combinationally with no clock edge needed.
- R7: A DMA line held high while it is wake-enabled and the mode field is 2'b11 sets its raw status bit on the third rising clock edge after the line rises. A high level that covers one rising edge is enough.
- R8: Raw status bits are sticky. Writing 1 to a raw bit (address 5/6) clears it, and writing 0 has no effect. When a capture and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: Writing 1 to a bit at the set address (9/10) sets that enable bit. Writing 1 at the clear address (11/12) clears it. Writing 0 to either address has no effect, and both addresses read back the current enable.
- R10: Masked status (address 7/8) reads raw status AND enable. Changing the enable does not change the raw bits.
- R11: `wake_irq` is high exactly when any masked status bit is set.
- R12: After reset, every register reads 0. The configuration register reads back only its mode field, and the mask registers read back as written.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Register and status clock (may be stopped during idle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_idle | input | 1 | High while the subsystem is in idle |
| irq_in | input | N_IRQ | Level-sensitive interrupt lines |
| dma_evt | input | N_DMA | Level-sensitive DMA event lines |
| nmi_in | input | 1 | Non-maskable interrupt, level-sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| wake_req | output | 1 | Combinational wakeup request to the power manager |
| wake_irq | output | 1 | OR of all masked DMA wake status bits |

## Verification
The request path is tried with one interrupt line in the low and one in the high enable word. These show that each enable bit selects its own line and that the mode field, the idle input and the enable each block the request alone. One interrupt line is then toggled with the clock held stopped, which shows that the request needs no clock. DMA lines are driven both unenabled and enabled, which separates request gating from status capture. A single-cycle DMA pulse is sampled after each of the first three edges to pin the capture latency and the stickiness. The non-maskable line is raised with all lines low to show it bypasses the masks. A clear is written while the event is still present, which separates set-over-clear priority from a plain clear. Writes of zero to the set, clear and raw-status addresses confirm that such writes change nothing.

// File: rtl/iwg_pkg.sv
package iwg_pkg;
  localparam int REG_W = 32;
  localparam int NWORD = 2;
  localparam int MW    = NWORD * REG_W;
  localparam int AW    = 4;

  localparam logic [1:0] WAKE_MODE = 2'b11;
  localparam int MODE_LSB = 2;

  localparam int ADR_CFG   = 0;
  localparam int ADR_IWEN0 = 1;
  localparam int ADR_DWEN0 = 3;
  localparam int ADR_RAW0  = 5;
  localparam int ADR_MSK0  = 7;
  localparam int ADR_SET0  = 9;
  localparam int ADR_CLR0  = 11;
endpackage

// File: rtl/iwg_wake_or.sv
module iwg_wake_or #(
  parameter int N_IRQ = 64,
  parameter int N_DMA = 64
) (
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_DMA-1:0] dma,
  input  logic [N_DMA-1:0] dma_en,
  input  logic             nmi,
  input  logic             mode_ok,
  input  logic             idle,
  output logic             irq_hit,
  output logic             dma_hit,
  output logic             wake
);
  // purely combinational: no storage anywhere on this path
  always_comb begin
    irq_hit = |(irq & irq_en);
    dma_hit = |(dma & dma_en);
    wake    = mode_ok & idle & (irq_hit | dma_hit | nmi);
  end
endmodule

// File: rtl/iwg_sync.sv
module iwg_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/iwg_evt_status.sv
module iwg_evt_status #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] raw_clr,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  output logic [W-1:0] raw,
  output logic [W-1:0] en,
  output logic [W-1:0] masked,
  output logic         any_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw[i] <= 1'b0;
        en[i]  <= 1'b0;
      end else begin
        // capture beats a same-cycle clear
        raw[i] <= hit[i] | (raw[i] & ~raw_clr[i]);
        if (en_set[i])      en[i] <= 1'b1;
        else if (en_clr[i]) en[i] <= 1'b0;
      end
    end
  end

  assign masked = raw & en;
  assign any_o  = |masked;
endmodule

// File: rtl/iwg_regs.sv
module iwg_regs
  import iwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [MW-1:0]    raw,
  input  logic [MW-1:0]    en,
  input  logic [MW-1:0]    masked,
  output logic [REG_W-1:0] rdata,
  output logic [1:0]       mode,
  output logic [MW-1:0]    irq_wen,
  output logic [MW-1:0]    dma_wen,
  output logic [MW-1:0]    raw_clr,
  output logic [MW-1:0]    en_set,
  output logic [MW-1:0]    en_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mode <= '0;
    else if (wr && addr == AW'(ADR_CFG)) mode <= wdata[MODE_LSB +: 2];
  end

  for (genvar k = 0; k < NWORD; k++) begin : g_word
    localparam logic [AW-1:0] A_IW = AW'(ADR_IWEN0 + k);
    localparam logic [AW-1:0] A_DW = AW'(ADR_DWEN0 + k);
    localparam logic [AW-1:0] A_RW = AW'(ADR_RAW0 + k);
    localparam logic [AW-1:0] A_ST = AW'(ADR_SET0 + k);
    localparam logic [AW-1:0] A_CL = AW'(ADR_CLR0 + k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_wen[k*REG_W +: REG_W] <= '0;
        dma_wen[k*REG_W +: REG_W] <= '0;
      end else if (wr) begin
        if (addr == A_IW) irq_wen[k*REG_W +: REG_W] <= wdata;
        if (addr == A_DW) dma_wen[k*REG_W +: REG_W] <= wdata;
      end
    end

    assign raw_clr[k*REG_W +: REG_W] = (wr && addr == A_RW) ? wdata : '0;
    assign en_set[k*REG_W +: REG_W]  = (wr && addr == A_ST) ? wdata : '0;
    assign en_clr[k*REG_W +: REG_W]  = (wr && addr == A_CL) ? wdata : '0;
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADR_CFG)) rdata[MODE_LSB +: 2] = mode;
    for (int k = 0; k < NWORD; k++) begin
      if (addr == AW'(ADR_IWEN0 + k)) rdata = irq_wen[k*REG_W +: REG_W];
      if (addr == AW'(ADR_DWEN0 + k)) rdata = dma_wen[k*REG_W +: REG_W];
      if (addr == AW'(ADR_RAW0 + k))  rdata = raw[k*REG_W +: REG_W];
      if (addr == AW'(ADR_MSK0 + k))  rdata = masked[k*REG_W +: REG_W];
      if (addr == AW'(ADR_SET0 + k) || addr == AW'(ADR_CLR0 + k))
        rdata = en[k*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/idle_wake_gen.sv
module idle_wake_gen
  import iwg_pkg::*;
#(
  parameter int N_IRQ = 64,
  parameter int N_DMA = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_idle,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_DMA-1:0] dma_evt,
  input  logic             nmi_in,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wake_req,
  output logic             wake_irq
);
  logic [1:0]       mode;
  logic             mode_ok;
  logic [MW-1:0]    irq_wen, dma_wen, raw_clr, en_set, en_clr;
  logic [MW-1:0]    raw_w, en_w, msk_w;
  logic [N_DMA-1:0] dma_sync, evt_hit, raw, en, msk;
  logic             irq_hit, dma_hit;

  assign mode_ok = (mode == WAKE_MODE);

  iwg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .raw     (raw_w),
    .en      (en_w),
    .masked  (msk_w),
    .rdata   (reg_rdata),
    .mode    (mode),
    .irq_wen (irq_wen),
    .dma_wen (dma_wen),
    .raw_clr (raw_clr),
    .en_set  (en_set),
    .en_clr  (en_clr)
  );

  iwg_wake_or #(.N_IRQ(N_IRQ), .N_DMA(N_DMA)) u_or (
    .irq     (irq_in),
    .irq_en  (irq_wen[N_IRQ-1:0]),
    .dma     (dma_evt),
    .dma_en  (dma_wen[N_DMA-1:0]),
    .nmi     (nmi_in),
    .mode_ok (mode_ok),
    .idle    (sys_idle),
    .irq_hit (irq_hit),
    .dma_hit (dma_hit),
    .wake    (wake_req)
  );

  iwg_sync #(.W(N_DMA)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dma_evt),
    .q     (dma_sync)
  );

  assign evt_hit = dma_sync & dma_wen[N_DMA-1:0] & {N_DMA{mode_ok}};

  iwg_evt_status #(.W(N_DMA)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (evt_hit),
    .raw_clr (raw_clr[N_DMA-1:0]),
    .en_set  (en_set[N_DMA-1:0]),
    .en_clr  (en_clr[N_DMA-1:0]),
    .raw     (raw),
    .en      (en),
    .masked  (msk),
    .any_o   (wake_irq)
  );

  assign raw_w = MW'(raw);
  assign en_w  = MW'(en);
  assign msk_w = MW'(msk);
endmodule

// File: rtl/iwg_chk.sv
module iwg_chk
  import iwg_pkg::*;
#(
  parameter int N_DMA = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_idle,
  input logic             nmi_in,
  input logic             wake_req,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [1:0]       mode,
  input logic             irq_hit,
  input logic             dma_hit,
  input logic [N_DMA-1:0] evt_hit,
  input logic [N_DMA-1:0] raw,
  input logic [MW-1:0]    en_w
);
  // R1
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != WAKE_MODE) |-> !wake_req);

  // R5
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_idle |-> !wake_req);

  // R4
  nmi_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_in && sys_idle && mode == WAKE_MODE) |-> wake_req);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_hit && !dma_hit && !nmi_in) |-> !wake_req);

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit != '0) |=> ((raw & $past(evt_hit)) == $past(evt_hit)));

  // R9
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADR_SET0))
      |=> ((en_w[REG_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

  // R9
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADR_CLR0))
      |=> ((en_w[REG_W-1:0] & $past(reg_wdata)) == '0));
endmodule

bind idle_wake_gen iwg_chk #(.N_DMA(N_DMA)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_idle  (sys_idle),
  .nmi_in    (nmi_in),
  .wake_req  (wake_req),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mode      (mode),
  .irq_hit   (irq_hit),
  .dma_hit   (dma_hit),
  .evt_hit   (evt_hit),
  .raw       (raw),
  .en_w      (en_w)
);

// File: tb/sim_idle_wake_gen.sv
module sim_idle_wake_gen;
  logic        clk = 1'b0;
  logic        clk_on = 1'b1;
  logic        rst_n = 1'b0;
  logic        sys_idle = 1'b0;
  logic [63:0] irq_in = '0;
  logic [63:0] dma_evt = '0;
  logic        nmi_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wake_req, wake_irq;

  always #10 if (clk_on) clk = ~clk;   // 50 MHz

  idle_wake_gen u0 (.*);

  typedef struct {
    int          kind;   // 0 rdata, 1 wake_req, 2 wake_irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  smp;
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  // monitor: pops expected items and compares against outputs
  initial forever begin
    @(smp);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? reg_rdata :
            (it.kind == 1) ? {31'b0, wake_req} : {31'b0, wake_irq};
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    #1;
    q.push_back(it);
    -> smp;
    #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    reg_addr = 4'(a);
    push(0, exp, tag);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: all requirements, actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    rd(0, 32'h0, "R12 cfg reset");
    rd(7, 32'h0, "R12 masked reset");
    rd(3, 32'h0, "R12 dma wen reset");
    push(1, 0, "R12 wake_req reset");
    push(2, 0, "R12 wake_irq reset");

    sys_idle = 1; irq_in[5] = 1;
    push(1, 0, "R1 mode 0 blocks");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'hC, "R12 cfg holds mode only");
    push(1, 0, "R2 line not enabled");
    wr(1, 32'h20);
    push(1, 1, "R2 enabled line wakes");
    rd(1, 32'h20, "R12 irq wen readback");
    wr(0, 32'h8);
    push(1, 0, "R1 mode 2 blocks");
    wr(0, 32'hC);
    push(1, 1, "R1 mode 3 restores");
    sys_idle = 0;
    push(1, 0, "R5 not idle");
    sys_idle = 1;
    push(1, 1, "R5 idle again");
    irq_in[5] = 0;
    push(1, 0, "R6 release");

    wr(2, 32'h100);
    clk_on = 0;
    irq_in[40] = 1;
    push(1, 1, "R2 high word line, clock stopped");
    irq_in[40] = 0;
    push(1, 0, "R6 release with clock stopped");
    clk_on = 1;
    cyc(1);

    dma_evt[33] = 1; dma_evt[2] = 1;
    push(1, 0, "R3 dma not enabled");
    cyc(4);
    rd(6, 32'h0, "R3 no capture when disabled");
    wr(4, 32'h2);
    push(1, 1, "R3 enabled dma wakes");
    cyc(4);
    rd(6, 32'h2, "R7 capture high word");
    rd(5, 32'h0, "R7 unenabled line not captured");
    dma_evt[33] = 0; dma_evt[2] = 0;
    push(1, 0, "R6 all enabled low");

    nmi_in = 1;
    push(1, 1, "R4 nmi without enables");
    wr(0, 32'h4);
    push(1, 0, "R1 nmi blocked by mode");
    wr(0, 32'hC);
    nmi_in = 0;
    push(1, 0, "R6 nmi released");

    wr(3, 32'h1);
    dma_evt[0] = 1;
    @(posedge clk); @(negedge clk);
    dma_evt[0] = 0;
    rd(5, 32'h0, "R7 not yet after edge 1");
    cyc(1);
    rd(5, 32'h0, "R7 not yet after edge 2");
    cyc(1);
    rd(5, 32'h1, "R7 set on edge 3");
    cyc(3);
    rd(5, 32'h1, "R8 sticky");
    wr(5, 32'h0);
    rd(5, 32'h1, "R8 write 0 no effect");
    wr(5, 32'h1);
    rd(5, 32'h0, "R8 write 1 clears");
    dma_evt[0] = 1;
    cyc(4);
    wr(5, 32'h1);
    rd(5, 32'h1, "R8 capture beats clear");
    dma_evt[0] = 0;
    cyc(3);
    wr(5, 32'h1);
    rd(5, 32'h0, "R8 clear after event gone");

    rd(8, 32'h0, "R10 masked with enable off");
    push(2, 0, "R11 no masked bit");
    wr(10, 32'h2);
    rd(10, 32'h2, "R9 set readback");
    rd(12, 32'h2, "R9 clear address readback");
    rd(8, 32'h2, "R10 masked follows enable");
    push(2, 1, "R11 wake_irq high");
    wr(10, 32'h0);
    rd(10, 32'h2, "R9 set write 0 no effect");
    wr(12, 32'h0);
    rd(10, 32'h2, "R9 clear write 0 no effect");
    wr(12, 32'h2);
    rd(10, 32'h0, "R9 clear write 1");
    rd(8, 32'h0, "R10 masked off");
    rd(6, 32'h2, "R10 raw untouched by enable");
    push(2, 0, "R11 wake_irq low");
    wr(9, 32'h1);
    rd(7, 32'h0, "R10 enable without raw");
    push(2, 0, "R11 enable alone");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule